// File: doc/BRIEF.md
# Two-Level Hierarchical Lookahead Adder

This block is a purely combinational 54-bit binary adder. It takes two operands and a carry-in, and it returns a 54-bit sum and a carry-out. The carry path is built as a tree so that no carry ripples from bit to bit.

First, a bitwise stage forms a propagate signal (the XOR of the operand bits) and a generate signal (their AND) for every bit position. These depend only on the operands, so all of them are ready at the same time. The bits are split into six 8-bit groups and one 6-bit top group. Each group expands its carry recurrence into sum-of-products form to get its internal carries. Each group also reports one group propagate and one group generate.

A second-level lookahead unit takes the seven group pairs and the external carry-in. From them it forms the carry entering every group. Each sum bit is then the bit propagate XOR the carry into that bit. The block is meant for wide datapaths that need a single-cycle add with short carry depth, such as mantissa arithmetic.

Top module: `hierLookaheadAdder`

## Requirements
- R1: For every operand pair and carry-in, {carryOut, sumOut} equals the 55-bit arithmetic sum opA + opB + carryIn.
- R2: Sum bit i equals opA[i] XOR opB[i] XOR (carry into bit i), where the carry into bit 0 is carryIn.
- R3: Carries cross group boundaries at bit positions 8, 16, 24, 32, 40 and 48. For example, 0xFF plus 1 gives 0x100 in the low groups.
- R4: When a group generates (its own bits produce a carry out of the group), the carry into the next group is 1, whatever the lower groups and carryIn hold.
- R5: When every bit of a group propagates (opA[i] != opB[i] for all its bits), the carry leaving the group equals the carry entering it. A full 54-bit propagate chain passes carryIn straight to carryOut.
- R6: The top group covers bits 48 to 53, and carryOut is the carry leaving bit 53. For example, 2^53 + 2^53 gives sum 0 and carryOut 1.
- R7: All ones plus one (either as opB = 1 or as carryIn = 1) gives sum 0 and carryOut 1.
- R8: With carryIn = 0, the result is exactly opA + opB. Setting carryIn = 1 with the same operands increases the 55-bit result by exactly one.
- R9: With all inputs zero, sumOut is 0 and carryOut is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 54 | First operand |
| opB | input | 54 | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | 54 | Sum bits |
| carryOut | output | 1 | Carry leaving bit 53 |

## Verification
The bench aims at the boundaries of the two-level tree:
- It sends a generate into each group edge. A second-level unit that picks the wrong group index, or a wrong group generate prefix, would drop or misplace the carry at bit 8k.
- It drives full propagate chains with carryIn set and clear. A group propagate formed wrongly, or a missing carry-in term in either lookahead level, would lose the carry or make one up.
- It targets the short 6-bit top group and the all-ones-plus-one case. If the last group were sized like the others, the carry-out would be taken from the wrong bit.
- Random vectors are compared against the language's own addition to catch stray product terms.

// File: rtl/hlaPkg.sv
package hlaPkg;
  // Propagate/generate pair reported by one lookahead group
  typedef struct packed {
    logic prop;
    logic gen;
  } pgPair_t;
endpackage

// File: rtl/pgUnit.sv
module pgUnit #(
  parameter int WIDTH = 54
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] prop,
  output logic [WIDTH-1:0] gen
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign prop[i] = a[i] ^ b[i];
    assign gen[i]  = a[i] & b[i];
  end
endmodule

// File: rtl/groupLookahead.sv
module groupLookahead
  import hlaPkg::*;
#(
  parameter int GW = 8
) (
  input  logic [GW-1:0] prop,
  input  logic [GW-1:0] gen,
  input  logic          cin,
  output logic [GW-1:0] carries,
  output pgPair_t       grp
);
  logic [GW:0] cVec;

  // Every carry written as a flat sum of products; no term feeds another carry
  always_comb begin
    cVec[0] = cin;
    for (int k = 1; k <= GW; k++) begin
      logic termAll;
      logic res;
      termAll = cin;
      for (int i = 0; i < k; i++) termAll = termAll & prop[i];
      res = termAll;
      for (int j = 0; j < k; j++) begin
        logic term;
        term = gen[j];
        for (int i = j + 1; i < k; i++) term = term & prop[i];
        res = res | term;
      end
      cVec[k] = res;
    end
  end

  assign carries = cVec[GW-1:0];

  always_comb begin
    logic gg;
    gg = gen[0];
    for (int i = 1; i < GW; i++) gg = gen[i] | (prop[i] & gg);
    grp.gen  = gg;
    grp.prop = &prop;
  end

  // Group summary must agree with the group's own carry leaving its top bit
  always_comb begin
    if (grp.gen) begin
      p_group_gen_r4: assert (cVec[GW] == 1'b1)
        else $error("group generate without carry out");
    end
    if (grp.prop) begin
      p_group_prop_r5: assert (cVec[GW] == cin)
        else $error("group propagate altered carry");
    end
  end
endmodule

// File: rtl/topLookahead.sv
module topLookahead #(
  parameter int NG = 7
) (
  input  logic [NG-1:0] groupProp,
  input  logic [NG-1:0] groupGen,
  input  logic          cin,
  output logic [NG-1:0] groupCin,
  output logic          cout
);
  logic [NG:0] cVec;

  always_comb begin
    cVec[0] = cin;
    for (int k = 1; k <= NG; k++) begin
      logic termAll;
      logic res;
      termAll = cin;
      for (int i = 0; i < k; i++) termAll = termAll & groupProp[i];
      res = termAll;
      for (int j = 0; j < k; j++) begin
        logic term;
        term = groupGen[j];
        for (int i = j + 1; i < k; i++) term = term & groupProp[i];
        res = res | term;
      end
      cVec[k] = res;
    end
  end

  assign groupCin = cVec[NG-1:0];
  assign cout     = cVec[NG];

  // Flat second-level products must match the step-by-step recurrence
  always_comb begin
    for (int i = 0; i < NG; i++) begin
      p_group_edge_r3: assert (cVec[i+1] == (groupGen[i] | (groupProp[i] & cVec[i])))
        else $error("second-level carry mismatch at group %0d", i);
    end
  end
endmodule

// File: rtl/hierLookaheadAdder.sv
module hierLookaheadAdder
  import hlaPkg::*;
#(
  parameter int WIDTH   = 54,
  parameter int GROUP_W = 8
) (
  input  logic [53:0] opA,
  input  logic [53:0] opB,
  input  logic        carryIn,
  output logic [53:0] sumOut,
  output logic        carryOut
);
  localparam int NG     = (WIDTH + GROUP_W - 1) / GROUP_W;
  localparam int LAST_W = WIDTH - (NG - 1) * GROUP_W;

  logic [WIDTH-1:0] bitProp;
  logic [WIDTH-1:0] bitGen;
  logic [WIDTH-1:0] carryVec;
  logic [NG-1:0]    groupProp;
  logic [NG-1:0]    groupGen;
  logic [NG-1:0]    groupCin;
  pgPair_t          grpPg [NG];

  pgUnit #(.WIDTH(WIDTH)) u_pg (
    .a(opA), .b(opB), .prop(bitProp), .gen(bitGen)
  );

  for (genvar g = 0; g < NG; g++) begin : g_grp
    localparam int LO = g * GROUP_W;
    localparam int W  = (g == NG - 1) ? LAST_W : GROUP_W;
    groupLookahead #(.GW(W)) u_grp (
      .prop   (bitProp[LO +: W]),
      .gen    (bitGen[LO +: W]),
      .cin    (groupCin[g]),
      .carries(carryVec[LO +: W]),
      .grp    (grpPg[g])
    );
    assign groupProp[g] = grpPg[g].prop;
    assign groupGen[g]  = grpPg[g].gen;
  end

  topLookahead #(.NG(NG)) u_top (
    .groupProp(groupProp),
    .groupGen (groupGen),
    .cin      (carryIn),
    .groupCin (groupCin),
    .cout     (carryOut)
  );

  assign sumOut = bitProp ^ carryVec;

  // Whole-word result against plain arithmetic
  always_comb begin
    p_total_sum_r1: assert ({carryOut, sumOut} ==
                            ({1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn}))
      else $error("adder result mismatch");
    p_low_bit_r2: assert (sumOut[0] == (opA[0] ^ opB[0] ^ carryIn))
      else $error("bit zero sum mismatch");
  end
endmodule

// File: tb/hierLookaheadAdder_test.sv
`timescale 1ns/1ps
module hierLookaheadAdder_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [53:0] opA = '0;
  logic [53:0] opB = '0;
  logic        carryIn = 1'b0;
  logic [53:0] sumOut;
  logic        carryOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  hierLookaheadAdder uut (
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .sumOut(sumOut), .carryOut(carryOut)
  );

  task automatic applyCheck(input string req, input logic [53:0] a,
                            input logic [53:0] b, input logic c);
    logic [54:0] expv;
    @(negedge clk);
    opA = a; opB = b; carryIn = c;
    #1;
    expv = {1'b0, a} + {1'b0, b} + {54'd0, c};
    checks++;
    if ({carryOut, sumOut} !== expv) begin
      errors++;
      $display("FAIL %s: a=%h b=%h cin=%b actual=%h expected=%h",
               req, a, b, c, {carryOut, sumOut}, expv);
    end
  endtask

  task automatic expectExact(input string req, input logic [54:0] want);
    checks++;
    if ({carryOut, sumOut} !== want) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, {carryOut, sumOut}, want);
    end
  endtask

  task automatic testZero();  // R9
    applyCheck("R9", '0, '0, 1'b0);
    expectExact("R9", 55'd0);
  endtask

  task automatic testLowBit();  // R2
    applyCheck("R2", 54'd1, 54'd0, 1'b1);
    expectExact("R2", 55'd2);
    applyCheck("R2", 54'd1, 54'd1, 1'b1);
    expectExact("R2", 55'd3);
  endtask

  task automatic testGroupEdges();  // R3
    for (int k = 1; k < 7; k++) begin
      logic [53:0] a;
      a = (54'd1 << (8 * k)) - 54'd1;
      applyCheck("R3", a, 54'd1, 1'b0);
      expectExact("R3", 55'd1 << (8 * k));
    end
  endtask

  task automatic testGenerate();  // R4
    for (int k = 0; k < 6; k++) begin
      logic [53:0] a;
      a = 54'h80 << (8 * k);
      applyCheck("R4", a | 54'h5, a, 1'b1);
      applyCheck("R4", a, a, 1'b0);
      expectExact("R4", 55'd1 << (8 * k + 8));
    end
  endtask

  task automatic testPropagateChain();  // R5
    logic [53:0] alt;
    alt = 54'h2AAAAAAAAAAAAA;
    applyCheck("R5", alt, ~alt, 1'b1);
    expectExact("R5", {1'b1, 54'd0});
    applyCheck("R5", alt, ~alt, 1'b0);
    expectExact("R5", {1'b0, {54{1'b1}}});
  endtask

  task automatic testTopGroup();  // R6
    applyCheck("R6", 54'd1 << 53, 54'd1 << 53, 1'b0);
    expectExact("R6", {1'b1, 54'd0});
    applyCheck("R6", 54'h3F << 48, 54'd1 << 48, 1'b0);
    expectExact("R6", {1'b1, 54'd0});
  endtask

  task automatic testAllOnes();  // R7
    applyCheck("R7", {54{1'b1}}, 54'd1, 1'b0);
    expectExact("R7", {1'b1, 54'd0});
    applyCheck("R7", {54{1'b1}}, 54'd0, 1'b1);
    expectExact("R7", {1'b1, 54'd0});
  endtask

  task automatic testCarryIn();  // R8
    for (int n = 0; n < 20; n++) begin
      logic [63:0] ra, rb;
      logic [54:0] first;
      ra = {$urandom(), $urandom()};
      rb = {$urandom(), $urandom()};
      applyCheck("R8", ra[53:0], rb[53:0], 1'b0);
      first = {carryOut, sumOut};
      applyCheck("R8", ra[53:0], rb[53:0], 1'b1);
      expectExact("R8", first + 55'd1);
    end
  endtask

  task automatic testRandom();  // R1
    for (int n = 0; n < 300; n++) begin
      logic [63:0] ra, rb;
      ra = {$urandom(), $urandom()};
      rb = {$urandom(), $urandom()};
      applyCheck("R1", ra[53:0], rb[53:0], 1'($urandom() & 1));
    end
  endtask

  initial begin
    fork
      begin
        testZero();
        testLowBit();
        testGroupEdges();
        testGenerate();
        testPropagateChain();
        testTopGroup();
        testAllOnes();
        testCarryIn();
        testRandom();
      end
      begin
        while (cycles < 200000) begin
          @(posedge clk);
          cycles++;
        end
        checks++;
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule